// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block serves a five-stage in-order pipeline. An instruction reads its operands in stage 2. Stage 3 is the ALU stage and stage 4 is the memory stage. For every source operand of the stage-2 instruction, the unit decides where the operand comes from. It can come from the register file, or it can be bypassed from a younger result still in flight in stage 3 or stage 4. The bypass choice depends on which value the producing stage will write back: an ALU result, loaded memory data, or an incremented PC used as a return address.

A load in stage 3 has no data yet. If a stage-2 operand depends on that load, the unit holds the PC and the fetch/decode register for one cycle. In the same cycle it turns the stage entering execute into a bubble, whose control fields are cleared. The pipeline predicts that branches are not taken. When a branch in stage 3 resolves as taken, the unit flushes the wrongly fetched instructions. The unit is combinational. Clock and reset feed only its embedded checks.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An operand whose register has no enabled write pending in stage 3 or stage 4 gets select code 2'b00 (register file).
- R2: If only stage 4 matches, the select is 2'b10 when stage 4 writes back a non-memory value (write-back source 2'b01 ALU or 2'b10 PC). It is 2'b11 when stage 4 writes back memory data (write-back source 2'b00).
- R3: A stage-3 match overrides any stage-4 match and gives select 2'b01. The per-operand alternate bit is 1 exactly when stage 3 matches and stage 3 carries the return-address flag.
- R4: If stage 3 is a load (write enabled, write-back source 2'b00) and its destination matches any nonzero source operand, both hold and bubble are 1 in that cycle.
- R5: Source register 0 is never forwarded and never causes a stall, whatever the downstream destinations are.
- R6: A stage whose write enable is 0 never matches, even when its destination equals the source.
- R7: A taken branch in stage 3 sets both flush and bubble to 1 and forces hold to 0. This holds even when a load-use condition is present at the same time.
- R8: Each operand's select and alternate bit are worked out independently. Two operands of one instruction may come from different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for checks |
| src_i | input | N_OPS x AW | Source register numbers of the stage-2 instruction |
| wr_en3_i | input | 1 | Stage-3 register write enable |
| dst3_i | input | AW | Stage-3 destination register |
| wb_src3_i | input | 2 | Stage-3 write-back source (00 memory, 01 ALU, 10 PC) |
| ret_addr3_i | input | 1 | Stage-3 writes a return address |
| wr_en4_i | input | 1 | Stage-4 register write enable |
| dst4_i | input | AW | Stage-4 destination register |
| wb_src4_i | input | 2 | Stage-4 write-back source (same encoding) |
| br_taken3_i | input | 1 | Branch in stage 3 resolved taken |
| sel_o | output | N_OPS x 2 | Per-operand bypass select |
| alt3_o | output | N_OPS | Per-operand stage-3 alternate (return address) select |
| hold_o | output | 1 | Hold PC and fetch/decode register |
| bubble_o | output | 1 | Clear control fields entering execute |
| flush_o | output | 1 | Flush wrongly fetched instruction |

## Verification
Several functions can act in the same cycle. One operand can stall on a stage-3 load while the other operand takes a stage-4 bypass. A single register can match both downstream stages at once. A taken branch can coincide with a load-use match. The bench provokes each of these with one vector that sets up both conditions together. It judges every output of that cycle against values derived from the priority and suppression rules. An operand that is not involved must keep its own independent select.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_S3  = 2'b01,
    SEL_S4P = 2'b10,
    SEL_S4A = 2'b11
  } fwd_sel_e;

  typedef enum logic [1:0] {
    WB_MEM = 2'b00,
    WB_ALU = 2'b01,
    WB_PC  = 2'b10
  } wb_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          wr_en_i,
  output logic          hit_o
);
  // register 0 discards writes, so it is never a bypass source
  assign hit_o = wr_en_i && (dst_i == src_i) && (src_i != '0);
endmodule

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] src_i,
  input  logic          wr_en3_i,
  input  logic [AW-1:0] dst3_i,
  input  logic          ret_addr3_i,
  input  logic          wr_en4_i,
  input  logic [AW-1:0] dst4_i,
  input  logic [1:0]    wb_src4_i,
  output logic [1:0]    sel_o,
  output logic          alt3_o,
  output logic          hit3_o
);
  logic hit3, hit4;

  fwd_match #(.AW(AW)) u_m3 (.src_i(src_i), .dst_i(dst3_i), .wr_en_i(wr_en3_i), .hit_o(hit3));
  fwd_match #(.AW(AW)) u_m4 (.src_i(src_i), .dst_i(dst4_i), .wr_en_i(wr_en4_i), .hit_o(hit4));

  always_comb begin
    sel_o = SEL_RF;
    if (hit3)                          sel_o = SEL_S3;
    else if (hit4 && wb_src4_i == WB_MEM) sel_o = SEL_S4A;
    else if (hit4)                     sel_o = SEL_S4P;
  end

  assign alt3_o = hit3 && ret_addr3_i;
  assign hit3_o = hit3;

  p_zero_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (sel_o == SEL_RF && !alt3_o));
  p_alt_needs_s3_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt3_o |-> (sel_o == SEL_S3));
  p_no_write_no_fwd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en3_i && !wr_en4_i) |-> (sel_o == SEL_RF));
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
  import fwd_pkg::*;
#(
  parameter int N_OPS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_OPS-1:0] hit3_i,
  input  logic [1:0]       wb_src3_i,
  input  logic             br_taken3_i,
  output logic             hold_o,
  output logic             bubble_o,
  output logic             flush_o
);
  logic load_use;

  assign load_use = (|hit3_i) && (wb_src3_i == WB_MEM);
  // a taken branch discards the stalled instruction, so holding is pointless
  assign hold_o   = load_use && !br_taken3_i;
  assign bubble_o = load_use || br_taken3_i;
  assign flush_o  = br_taken3_i;

  p_hold_bubble_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> bubble_o);
  p_taken_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken3_i |-> (flush_o && bubble_o && !hold_o));
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_pkg::*;
#(
  parameter int AW    = 5,
  parameter int N_OPS = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_OPS-1:0][AW-1:0]  src_i,
  input  logic                      wr_en3_i,
  input  logic [AW-1:0]             dst3_i,
  input  logic [1:0]                wb_src3_i,
  input  logic                      ret_addr3_i,
  input  logic                      wr_en4_i,
  input  logic [AW-1:0]             dst4_i,
  input  logic [1:0]                wb_src4_i,
  input  logic                      br_taken3_i,
  output logic [N_OPS-1:0][1:0]     sel_o,
  output logic [N_OPS-1:0]          alt3_o,
  output logic                      hold_o,
  output logic                      bubble_o,
  output logic                      flush_o
);
  logic [N_OPS-1:0] hit3;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fwd_select #(.AW(AW)) u_sel (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .src_i       (src_i[g]),
      .wr_en3_i    (wr_en3_i),
      .dst3_i      (dst3_i),
      .ret_addr3_i (ret_addr3_i),
      .wr_en4_i    (wr_en4_i),
      .dst4_i      (dst4_i),
      .wb_src4_i   (wb_src4_i),
      .sel_o       (sel_o[g]),
      .alt3_o      (alt3_o[g]),
      .hit3_o      (hit3[g])
    );
  end

  load_use_detect #(.N_OPS(N_OPS)) u_lu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit3_i      (hit3),
    .wb_src3_i   (wb_src3_i),
    .br_taken3_i (br_taken3_i),
    .hold_o      (hold_o),
    .bubble_o    (bubble_o),
    .flush_o     (flush_o)
  );

  p_hold_needs_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (wr_en3_i && wb_src3_i == WB_MEM && dst3_i != '0));
endmodule

// File: tb/sim_fwd_hazard_unit.sv
module sim_fwd_hazard_unit;
  localparam int AW = 5;
  localparam int N_OPS = 2;

  typedef struct packed {
    logic [4:0] a, b;
    logic       we3; logic [4:0] d3; logic [1:0] wb3; logic ret3;
    logic       we4; logic [4:0] d4; logic [1:0] wb4;
    logic       tk;
    logic [1:0] e_sa; logic e_aa; logic [1:0] e_sb; logic e_ab;
    logic       e_hold, e_bub, e_fl;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  // wb: 00 mem, 01 alu, 10 pc ; sel: 00 rf, 01 s3, 10 s4 primary, 11 s4 alt
  localparam vec_t VEC [NV] = '{
    '{5'd1, 5'd2, 1'b1,5'd5,2'b01,1'b0, 1'b1,5'd6,2'b01, 1'b0, 2'b00,1'b0,2'b00,1'b0, 1'b0,1'b0,1'b0, 4'd1}, // R1
    '{5'd5, 5'd2, 1'b1,5'd5,2'b01,1'b0, 1'b0,5'd0,2'b01, 1'b0, 2'b01,1'b0,2'b00,1'b0, 1'b0,1'b0,1'b0, 4'd3}, // R3 back-to-back
    '{5'd3, 5'd7, 1'b1,5'd9,2'b01,1'b0, 1'b1,5'd7,2'b01, 1'b0, 2'b00,1'b0,2'b10,1'b0, 1'b0,1'b0,1'b0, 4'd2}, // R2 distance two
    '{5'd3, 5'd7, 1'b0,5'd7,2'b01,1'b0, 1'b1,5'd7,2'b00, 1'b0, 2'b00,1'b0,2'b11,1'b0, 1'b0,1'b0,1'b0, 4'd2}, // R2 stage-4 load
    '{5'd8, 5'd8, 1'b1,5'd8,2'b01,1'b0, 1'b1,5'd8,2'b00, 1'b0, 2'b01,1'b0,2'b01,1'b0, 1'b0,1'b0,1'b0, 4'd3}, // R3 double match
    '{5'd31,5'd1, 1'b1,5'd31,2'b10,1'b1, 1'b0,5'd0,2'b01, 1'b0, 2'b01,1'b1,2'b00,1'b0, 1'b0,1'b0,1'b0, 4'd3}, // R3 return address
    '{5'd4, 5'd10,1'b1,5'd10,2'b00,1'b0, 1'b1,5'd4,2'b01, 1'b0, 2'b10,1'b0,2'b01,1'b0, 1'b1,1'b1,1'b0, 4'd4}, // R4 load-use + bypass
    '{5'd0, 5'd0, 1'b1,5'd0,2'b00,1'b0, 1'b1,5'd0,2'b01, 1'b0, 2'b00,1'b0,2'b00,1'b0, 1'b0,1'b0,1'b0, 4'd5}, // R5 register 0
    '{5'd12,5'd12,1'b0,5'd12,2'b00,1'b0, 1'b0,5'd12,2'b01, 1'b0, 2'b00,1'b0,2'b00,1'b0, 1'b0,1'b0,1'b0, 4'd6}, // R6 writes off
    '{5'd13,5'd2, 1'b0,5'd13,2'b01,1'b1, 1'b1,5'd13,2'b00, 1'b0, 2'b11,1'b0,2'b00,1'b0, 1'b0,1'b0,1'b0, 4'd6}, // R6 s3 off, s4 on
    '{5'd6, 5'd9, 1'b1,5'd6,2'b01,1'b0, 1'b1,5'd9,2'b01, 1'b0, 2'b01,1'b0,2'b10,1'b0, 1'b0,1'b0,1'b0, 4'd8}, // R8 split sources
    '{5'd3, 5'd4, 1'b0,5'd0,2'b01,1'b0, 1'b0,5'd0,2'b01, 1'b1, 2'b00,1'b0,2'b00,1'b0, 1'b0,1'b1,1'b1, 4'd7}, // R7 taken branch
    '{5'd10,5'd1, 1'b1,5'd10,2'b00,1'b0, 1'b0,5'd0,2'b01, 1'b1, 2'b01,1'b0,2'b00,1'b0, 1'b0,1'b1,1'b1, 4'd7}  // R7 taken + load-use
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_OPS-1:0][AW-1:0] src;
  logic we3, ret3, we4, tk;
  logic [AW-1:0] d3, d4;
  logic [1:0] wb3, wb4;
  logic [N_OPS-1:0][1:0] sel;
  logic [N_OPS-1:0] alt3;
  logic hold, bubble, flush;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fwd_hazard_unit #(.AW(AW), .N_OPS(N_OPS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .wr_en3_i(we3), .dst3_i(d3), .wb_src3_i(wb3), .ret_addr3_i(ret3),
    .wr_en4_i(we4), .dst4_i(d4), .wb_src4_i(wb4), .br_taken3_i(tk),
    .sel_o(sel), .alt3_o(alt3), .hold_o(hold), .bubble_o(bubble), .flush_o(flush)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (sa,aa,sb,ab,hold,bub,fl)", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    src[0] = v.a; src[1] = v.b;
    we3 = v.we3; d3 = v.d3; wb3 = v.wb3; ret3 = v.ret3;
    we4 = v.we4; d4 = v.d4; wb4 = v.wb4; tk = v.tk;
  endtask

  initial begin
    src = '0; we3 = 0; d3 = '0; wb3 = 2'b01; ret3 = 0;
    we4 = 0; d4 = '0; wb4 = 2'b01; tk = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state: idle inputs select the register file, no stall
    check("R1", {sel[0], alt3[0], sel[1], alt3[1], hold, bubble, flush}, 9'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      check($sformatf("R%0d vec%0d", VEC[i].req, i),
            {sel[0], alt3[0], sel[1], alt3[1], hold, bubble, flush},
            {VEC[i].e_sa, VEC[i].e_aa, VEC[i].e_sb, VEC[i].e_ab, VEC[i].e_hold, VEC[i].e_bub, VEC[i].e_fl});
    end
    // R3 return flag without a stage-3 match leaves alternate bit low
    @(negedge clk);
    src[0] = 5'd14; src[1] = 5'd15; we3 = 1; d3 = 5'd16; wb3 = 2'b10; ret3 = 1;
    we4 = 1; d4 = 5'd14; wb4 = 2'b10; tk = 0;
    #1;
    check("R3 ret flag no match", {sel[0], alt3[0], sel[1], alt3[1], hold, bubble, flush},
          {2'b10, 1'b0, 2'b00, 1'b0, 3'b000});
    // R4 load in stage 3 on operand a only, other operand unaffected
    @(negedge clk);
    src[0] = 5'd20; src[1] = 5'd21; we3 = 1; d3 = 5'd20; wb3 = 2'b00; ret3 = 0;
    we4 = 0; tk = 0;
    #1;
    check("R4 load-use on a", {sel[0], alt3[0], sel[1], alt3[1], hold, bubble, flush},
          {2'b01, 1'b0, 2'b00, 1'b0, 3'b110});
    // R5 load to register 0 with operand 0 does not stall
    @(negedge clk);
    src[0] = 5'd0; src[1] = 5'd0; we3 = 1; d3 = 5'd0; wb3 = 2'b00; tk = 0;
    #1;
    check("R5 load to r0", {sel[0], alt3[0], sel[1], alt3[1], hold, bubble, flush}, 9'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule